// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM of 32K words by 8 bits. It takes one single-word request at a time over a valid/ready handshake. It then plays out the chip-select, write-enable and output-enable strobes over as many clock cycles as the memory's nanosecond minimums demand. Read data comes back on a one-cycle response strobe. Writes also end with a response strobe, so the requester can see when the write cycle has finished.

Every interval is a parameter given in nanoseconds, together with the clock period in picoseconds. Each interval becomes a cycle count, rounded up, and is never less than one cycle. The sequencer drives the shared 8-bit data bus only during writes. It turns its drivers on a bus-release delay after write enable falls, and it does not start a new access until the same delay has passed after output enable rises. This keeps the controller and the memory from driving the bus at the same time.

Top module: `asram_ctl`

## Requirements
- R1: During and after reset, until the first accepted request, the three active-low strobes are high, the data drivers are off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only when `req_ready` is 1. `req_ready` stays 0 from the acceptance edge until the access has finished. Changes to `req_write`, `req_addr` or `req_wdata` while busy do not alter the access in progress.
- R3: A read holds chip select low, output enable low and write enable high for N_RD = max(ceil(access), ceil(output-enable access), ceil(cycle time)) cycles. It samples the bus at the edge that ends this window.
- R4: During a write pulse (write enable low), chip select is low, output enable is high and the address is constant. The pulse lasts N_PULSE = max(ceil(pulse width), ceil(bus release)+ceil(data setup), ceil(address-to-end)) cycles, and this is at least ceil(pulse width).
- R5: Write data is driven no sooner than ceil(bus release) cycles after write enable falls. It is stable for at least ceil(data setup) cycles before write enable rises and is still driven in the cycle after it rises. It is never driven while output enable is low.
- R6: After a write pulse, write enable stays high for N_REC = max(ceil(recovery), ceil(cycle time) − N_PULSE) cycles before the write's response. Accept-to-response takes 1 + N_PULSE + N_REC cycles.
- R7: After a read, at least ceil(bus release) cycles with output enable high pass before `req_ready` returns to 1.
- R8: Cycle counts are ceil(ns·1000 / CLK_PS), with a minimum of 1. With a 5000 ps clock and a 47 ns access time, a read has an accept-to-response latency of 10 cycles.
- R9: `rsp_valid` is a single-cycle pulse. For a read, `rsp_rdata` carries the word sampled at the end of the read window, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (15) | Word address |
| req_wdata | input | DW (8) | Write data |
| rsp_valid | output | 1 | Access complete, one-cycle pulse |
| rsp_rdata | output | DW (8) | Read data, valid with `rsp_valid` after a read |
| mem_addr | output | AW (15) | Memory address lines |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq | inout | DW (8) | Shared data bus |

## Verification
The assertions assume the memory obeys its own timing. That is, it drives the bus only while chip select and output enable are low with write enable high, and it presents correct data only once the access window has passed. They also assume requests follow the handshake and that reset is asserted before the first clock edge. The bench memory model puts the inverted word on the bus until the bench's own rounded access count has passed since the last strobe or address change. It never drives during writes. Requests are presented only at falling edges, and valid is released on the falling edge at which the response is seen, so the scrambled payload that is held during busy periods is never taken as a new request.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACCESS,
      ST_RD_SAMPLE,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RECOVER,
      ST_TURNAROUND
   } asram_state_e;

   // nanoseconds to clock cycles, rounded up, at least one
   function automatic int ns_to_cycles(input int ns, input int clk_ps);
      int c;
      c = (ns * 1000 + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] cnt,
   output logic          expired
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - CW'(1);
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/asram_dq.sv
module asram_dq #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_wdata,
   input  logic [DW-1:0] wdata_in,
   input  logic          capture,
   input  logic [DW-1:0] dq_in,
   output logic [DW-1:0] dq_out,
   output logic [DW-1:0] rdata
);

   // write word is frozen at acceptance so busy-time payload changes are ignored
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dq_out <= '0;
      else if (load_wdata)
         dq_out <= wdata_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (capture)
         rdata <= dq_in;
   end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
   import asram_pkg::*;
#(
   parameter int CLK_PS    = 10000,
   parameter int AW        = 15,
   parameter int DW        = 8,
   parameter int T_ACC_NS  = 50,
   parameter int T_OE_NS   = 20,
   parameter int T_CYC_NS  = 50,
   parameter int T_WP_NS   = 45,
   parameter int T_DS_NS   = 35,
   parameter int T_AVW_NS  = 45,
   parameter int T_WR_NS   = 5,
   parameter int T_OZ_NS   = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_cs_n,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   inout  wire  [DW-1:0] mem_dq
);

   // ---------------- derived cycle counts ----------------
   localparam int C_ACC   = ns_to_cycles(T_ACC_NS, CLK_PS);
   localparam int C_OE    = ns_to_cycles(T_OE_NS, CLK_PS);
   localparam int C_CYC   = ns_to_cycles(T_CYC_NS, CLK_PS);
   localparam int C_WP    = ns_to_cycles(T_WP_NS, CLK_PS);
   localparam int C_DS    = ns_to_cycles(T_DS_NS, CLK_PS);
   localparam int C_AVW   = ns_to_cycles(T_AVW_NS, CLK_PS);
   localparam int C_WR    = ns_to_cycles(T_WR_NS, CLK_PS);
   localparam int C_OZ    = ns_to_cycles(T_OZ_NS, CLK_PS);

   localparam int N_RD    = imax(imax(C_ACC, C_OE), C_CYC);
   localparam int N_PULSE = imax(imax(C_WP, C_OZ + C_DS), C_AVW);
   localparam int N_REC   = imax(C_WR, C_CYC - N_PULSE);
   localparam int N_TA    = C_OZ;
   localparam int CNT_MAX = imax(imax(N_RD, N_PULSE), imax(N_REC, N_TA));
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam int DRV_AT  = N_PULSE - 1 - C_OZ;

   // ---------------- elaboration checks ----------------
   generate
      if (CLK_PS < 1) begin : g_chk_clk
         $error("asram_ctl: CLK_PS must be positive");
      end
      if (AW < 1 || DW < 1) begin : g_chk_width
         $error("asram_ctl: AW and DW must be positive");
      end
      if (CNT_MAX > 250) begin : g_chk_range
         $error("asram_ctl: interval counts exceed supported range");
      end
      if (T_ACC_NS < 0 || T_OE_NS < 0 || T_CYC_NS < 0 || T_WP_NS < 0 ||
          T_DS_NS < 0 || T_AVW_NS < 0 || T_WR_NS < 0 || T_OZ_NS < 0) begin : g_chk_ns
         $error("asram_ctl: timing values must not be negative");
      end
   endgenerate

   // ---------------- state ----------------
   asram_state_e  state, state_d;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic [CW-1:0] tmr_cnt;
   logic          tmr_expired;
   logic          accept;
   logic          capture;
   logic          rsp_d;
   logic          drive;
   logic [DW-1:0] dq_out;

   asram_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cnt      (tmr_cnt),
      .expired  (tmr_expired)
   );

   always_comb begin
      state_d  = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      rsp_d    = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               if (req_write) begin
                  state_d = ST_WR_SETUP;
               end else begin
                  state_d  = ST_RD_ACCESS;
                  tmr_load = 1'b1;
                  tmr_val  = CW'(N_RD - 1);
               end
            end
         end
         ST_RD_ACCESS: begin
            if (tmr_expired) begin
               capture = 1'b1;
               rsp_d   = 1'b1;
               state_d = ST_RD_SAMPLE;
            end
         end
         ST_RD_SAMPLE: begin
            state_d  = ST_TURNAROUND;
            tmr_load = 1'b1;
            tmr_val  = CW'(N_TA - 1);
         end
         ST_TURNAROUND: begin
            if (tmr_expired) state_d = ST_IDLE;
         end
         ST_WR_SETUP: begin
            state_d  = ST_WR_PULSE;
            tmr_load = 1'b1;
            tmr_val  = CW'(N_PULSE - 1);
         end
         ST_WR_PULSE: begin
            if (tmr_expired) begin
               state_d  = ST_WR_RECOVER;
               tmr_load = 1'b1;
               tmr_val  = CW'(N_REC - 1);
            end
         end
         ST_WR_RECOVER: begin
            if (tmr_expired) begin
               state_d = ST_IDLE;
               rsp_d   = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mem_cs_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_addr  <= '0;
         rsp_valid <= 1'b0;
      end else begin
         state     <= state_d;
         mem_cs_n  <= !(state_d == ST_RD_ACCESS || state_d == ST_WR_SETUP ||
                        state_d == ST_WR_PULSE  || state_d == ST_WR_RECOVER);
         mem_we_n  <= (state_d != ST_WR_PULSE);
         mem_oe_n  <= (state_d != ST_RD_ACCESS);
         rsp_valid <= rsp_d;
         if (accept) mem_addr <= req_addr;
      end
   end

   assign req_ready = (state == ST_IDLE);

   // drivers come on only once the memory's output release time has run out
   assign drive = ((state == ST_WR_PULSE) && (tmr_cnt <= CW'(DRV_AT))) ||
                  (state == ST_WR_RECOVER);

   asram_dq #(.DW(DW)) u_dq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_wdata (accept & req_write),
      .wdata_in   (req_wdata),
      .capture    (capture),
      .dq_in      (mem_dq),
      .dq_out     (dq_out),
      .rdata      (rsp_rdata)
   );

   assign mem_dq = drive ? dq_out : {DW{1'bz}};

   // ---------------- assertions ----------------
   logic [7:0] we_low_c, oe_low_c, oe_high_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_c  <= '0;
         oe_low_c  <= '0;
         oe_high_c <= 8'hFF;
      end else begin
         we_low_c  <= mem_we_n ? 8'd0 : ((we_low_c == 8'hFF) ? we_low_c : we_low_c + 8'd1);
         oe_low_c  <= mem_oe_n ? 8'd0 : ((oe_low_c == 8'hFF) ? oe_low_c : oe_low_c + 8'd1);
         oe_high_c <= !mem_oe_n ? 8'd0 : ((oe_high_c == 8'hFF) ? oe_high_c : oe_high_c + 8'd1);
      end
   end

   a_r3_read_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (int'(oe_low_c) >= N_RD));

   a_r3_read_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

   a_r4_pulse_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_oe_n && $stable(mem_addr)));

   a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (int'(we_low_c) >= C_WP));

   a_r5_drive_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive) |-> (!mem_we_n && int'(we_low_c) >= C_OZ));

   a_r5_no_drive_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> mem_oe_n);

   a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> (int'(oe_high_c) >= C_OZ));

   a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: tb/asram_ctl_tb.sv
module asram_ctl_tb;

   localparam int PER_PS  = 5000;
   localparam int ACC_NS  = 47;
   localparam int OE_NS   = 20;
   localparam int CYC_NS  = 40;
   localparam int WP_NS   = 45;
   localparam int DS_NS   = 35;
   localparam int AVW_NS  = 45;
   localparam int WR_NS   = 5;
   localparam int OZ_NS   = 15;

   function automatic int up(input int ns);
      int c;
      c = (ns * 1000 + PER_PS - 1) / PER_PS;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int NEED_RD  = mx(mx(up(ACC_NS), up(OE_NS)), up(CYC_NS));
   localparam int NEED_WP  = up(WP_NS);
   localparam int NEED_DS  = up(DS_NS);
   localparam int NEED_WR  = up(WR_NS);
   localparam int NEED_OZ  = up(OZ_NS);
   localparam int EXP_PULSE = mx(mx(NEED_WP, NEED_OZ + NEED_DS), up(AVW_NS));
   localparam int EXP_WLAT  = 1 + EXP_PULSE + mx(NEED_WR, up(CYC_NS) - EXP_PULSE);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [14:0] mem_addr;
   logic        mem_cs_n, mem_we_n, mem_oe_n;
   wire  [7:0]  mem_dq;

   asram_ctl #(
      .CLK_PS(PER_PS), .T_ACC_NS(ACC_NS), .T_OE_NS(OE_NS), .T_CYC_NS(CYC_NS),
      .T_WP_NS(WP_NS), .T_DS_NS(DS_NS), .T_AVW_NS(AVW_NS), .T_WR_NS(WR_NS),
      .T_OZ_NS(OZ_NS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [7:0] mdl_mem [int];
   function automatic logic [7:0] mdl_read(input int a);
      if (mdl_mem.exists(a)) return mdl_mem[a];
      return 8'(a) ^ 8'h5A;
   endfunction

   logic        mdl_drive;
   logic [7:0]  mdl_val = '0;
   assign mdl_drive = !mem_cs_n && !mem_oe_n && mem_we_n;
   assign mem_dq = mdl_drive ? mdl_val : 8'hzz;

   int          age = 0;
   logic [17:0] snap = '1;
   bit          prev_we_n = 1'b1;
   int          wl_cnt = 0, wh_cnt = 1000, stab = 0;
   logic [7:0]  last_dq = '0;
   logic [14:0] pulse_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if ({mem_addr, mem_cs_n, mem_we_n, mem_oe_n} != snap) age = 0;
         else age = age + 1;
         snap = {mem_addr, mem_cs_n, mem_we_n, mem_oe_n};
         mdl_val <= (age + 1 >= NEED_RD) ? mdl_read(int'(mem_addr)) : ~mdl_read(int'(mem_addr));
         if (!mem_we_n) begin
            if (prev_we_n) begin
               chk(wh_cnt >= NEED_WR, "R6 write-high recovery", wh_cnt, NEED_WR);
               pulse_addr = mem_addr;
               wl_cnt = 0;
               stab = 0;
            end
            wl_cnt = wl_cnt + 1;
            if (stab > 0 && mem_dq == last_dq) stab = stab + 1;
            else stab = 1;
            last_dq = mem_dq;
            if (mem_addr != pulse_addr || mem_cs_n || !mem_oe_n)
               chk(1'b0, "R4 strobes/address during pulse", int'(mem_addr), int'(pulse_addr));
         end else begin
            if (!prev_we_n) begin
               chk(wl_cnt >= NEED_WP, "R4 write pulse width", wl_cnt, NEED_WP);
               chk(stab >= NEED_DS, "R5 data setup before end of write", stab, NEED_DS);
               chk(mem_dq == last_dq, "R5 data held after end of write", int'(mem_dq), int'(last_dq));
               mdl_mem[int'(pulse_addr)] = last_dq;
               wh_cnt = 0;
            end
            wh_cnt = wh_cnt + 1;
         end
         prev_we_n = mem_we_n;
      end
   end

   // ---------------- request driver ----------------
   int last_lat;
   int last_ta;
   logic [7:0] last_rd;

   task automatic do_req(input bit wr, input logic [14:0] a, input logic [7:0] d);
      int lat;
      bit busy_ok;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      // busy: scramble payload, keep valid up (R2)
      req_write = 1'b1; req_addr = a ^ 15'h1; req_wdata = ~d;
      lat = 0;
      busy_ok = 1'b1;
      while (!rsp_valid && lat < 1000) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         lat++;
      end
      req_valid = 1'b0;
      chk(busy_ok, "R2 ready low while busy", int'(busy_ok), 1);
      last_lat = lat;
      last_rd  = rsp_rdata;
      @(negedge clk);
      chk(!rsp_valid, "R9 response is one cycle", int'(rsp_valid), 0);
      last_ta = 1;
      while (!req_ready && last_ta < 1000) begin
         @(negedge clk);
         last_ta++;
      end
   endtask

   typedef struct packed {
      logic        wr;
      logic [14:0] addr;
      logic [7:0]  data;
   } vec_t;

   localparam vec_t VEC [0:10] = '{
      '{1'b1, 15'h0010, 8'hA5},
      '{1'b0, 15'h0010, 8'hA5},
      '{1'b1, 15'h7FFF, 8'h3C},
      '{1'b1, 15'h0000, 8'hC3},
      '{1'b0, 15'h7FFF, 8'h3C},
      '{1'b0, 15'h0000, 8'hC3},
      '{1'b0, 15'h1234, 8'h6E},
      '{1'b1, 15'h0010, 8'h81},
      '{1'b0, 15'h0010, 8'h81},
      '{1'b1, 15'h2AAA, 8'h0F},
      '{1'b0, 15'h2AAA, 8'h0F}
   };

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes inactive in reset",
          int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
      chk(req_ready && !rsp_valid, "R1 ready/rsp in reset", int'({req_ready, rsp_valid}), 2);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes inactive after reset",
          int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
      chk(req_ready && !rsp_valid, "R1 idle after reset", int'({req_ready, rsp_valid}), 2);

      for (int i = 0; i <= 10; i++) begin
         do_req(VEC[i].wr, VEC[i].addr, VEC[i].data);
         if (VEC[i].wr) begin
            chk(last_lat == EXP_WLAT, "R6 write accept-to-response cycles", last_lat, EXP_WLAT);
         end else begin
            chk(last_rd == VEC[i].data, "R3 R9 read data", int'(last_rd), int'(VEC[i].data));
            chk(last_lat == NEED_RD, "R8 read latency from rounded counts", last_lat, NEED_RD);
            chk(last_ta >= NEED_OZ, "R7 turnaround before ready", last_ta, NEED_OZ);
         end
      end

      // R2 scrambled payload during a write must not reach the memory at a^1
      do_req(1'b0, 15'h0011, 8'h00);
      chk(last_rd == (8'h11 ^ 8'h5A), "R2 neighbour untouched by busy payload",
          int'(last_rd), int'(8'h11 ^ 8'h5A));

      // R5/R6 back-to-back writes with valid raised straight after response
      do_req(1'b1, 15'h0100, 8'h11);
      do_req(1'b1, 15'h0101, 8'h22);
      do_req(1'b0, 15'h0100, 8'h00);
      chk(last_rd == 8'h11, "R5 first of back-to-back writes", int'(last_rd), 8'h11);
      do_req(1'b0, 15'h0101, 8'h00);
      chk(last_rd == 8'h22, "R5 second of back-to-back writes", int'(last_rd), 8'h22);

      repeat (3) @(negedge clk);
      chk(mem_cs_n && mem_we_n && mem_oe_n && req_ready, "R1 idle strobes after traffic",
          int'({mem_cs_n, mem_we_n, mem_oe_n, req_ready}), 15);

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule